// File: doc/BRIEF.md
# Strap-Loaded Indexed Configuration Register Bank

This block holds the setup registers of a two-channel serial controller that also has a watchdog. A host on a simple I/O bus reaches it through two byte-wide ports. A write to the first port, the selector port, picks a register number. A read or write at the next address, the window port, then reaches the register that number selects. A device-select register picks which of three register sets the per-device numbers refer to. Set 0 is serial channel A, set 1 is serial channel B and set 2 is the watchdog.

Each set holds an enable bit, a 16-bit base address stored as two bytes and a 4-bit interrupt select. The reset values of these registers do not come from constants. They come from strap inputs that the block samples while reset is held, and a separate strap picks which address pair serves as the selector and window ports. Once reset is released the straps are ignored. Software may then rewrite every loaded value.

Top module: `cfg_strap_bank`

## Requirements
- R1: While `rst_n` is low the block samples `strap_port`. A sampled 1 puts the selector port at 0x002E and the window port at 0x002F. A sampled 0 puts them at 0x004E and 0x004F. Reads and writes at any other address have no effect and read as 0x00.
- R2: A write to the selector port stores the 8-bit register number, and a read of the selector port returns it. A read or write of the window port reaches the register that the stored number selects. The register numbers are: 0x07 device select, 0x30 enable (bit 0), 0x60 base address bits 15:8, 0x61 base address bits 7:0, 0x70 interrupt select (bits 3:0). Unused bits read as 0.
- R3: Channel A defaults: with `strap_a_3f8` high, enable 1, base 0x03F8 and interrupt select 3, even when `strap_a_3e0` is also high. With only `strap_a_3e0` high, enable 1, base 0x03E0 and interrupt select 3. With neither strap high, all fields are 0.
- R4: Channel B defaults: with `strap_b_2f8` high, enable 1, base 0x02F8 and interrupt select 4, even when `strap_b_2e0` is also high. With only `strap_b_2e0` high, enable 1, base 0x02E0 and interrupt select 4. With neither strap high, all fields are 0.
- R5: Watchdog defaults: with `strap_wdt` high, enable 1, base 0x0442 and interrupt select 0. With `strap_wdt` low, all fields are 0.
- R6: After reset, a window write to 0x30, 0x60, 0x61 or 0x70 replaces that field of the selected set. Every register keeps its value when it is not written.
- R7: Changing any strap input after reset leaves every register value and the port pair unchanged.
- R8: A window read of any register number other than 0x07, 0x30, 0x60, 0x61 or 0x70 returns 0x00, and a window write to such a number changes nothing. The same holds for 0x30 to 0x70 while the device select holds a value of 3 or more.
- R9: The device select register at 0x07 stores 8 bits, resets to 0x00 and reads back what was written. Values 0, 1 and 2 pick channel A, channel B and the watchdog.
- R10: `io_rdata` is registered. It carries the read result in the cycle after the cycle in which `io_rd` is high, and it is 0x00 in every other cycle. A write takes effect at the clock edge where `io_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap_port | input | 1 | Port pair select strap (1: 0x2E/0x2F, 0: 0x4E/0x4F) |
| strap_a_3f8 | input | 1 | Channel A strap for base 0x03F8 |
| strap_a_3e0 | input | 1 | Channel A strap for base 0x03E0 |
| strap_b_2f8 | input | 1 | Channel B strap for base 0x02F8 |
| strap_b_2e0 | input | 1 | Channel B strap for base 0x02E0 |
| strap_wdt | input | 1 | Watchdog enable strap |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |

## Verification
A write changes state at the clock edge where its strobe is high, so a read that issues in the next cycle already sees the new value. Read data is due exactly one edge after the read strobe, and it must be zero in every cycle that has no read. A behavioural model in the bench holds the register sets in integer arrays and updates them at each rising edge. The bench compares its expected read data with `io_rdata` at every falling edge. On top of that comparison, directed reads check the strap defaults, the precedence between straps, the port pair and the device select, and each of these reads is also sampled at the falling edge after its strobe.

// File: rtl/cfgbank_pkg.sv
// Package: shared constants and types for the strap-loaded configuration bank.
// Assumes byte-wide host data and 16-bit I/O addresses.
package cfgbank_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int NUM_DEV = 3;   // 0: channel A, 1: channel B, 2: watchdog
    localparam int IRQ_W   = 4;

    localparam logic [7:0] IDX_DEVSEL  = 8'h07;
    localparam logic [7:0] IDX_ENABLE  = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam logic [7:0] IDX_IRQ     = 8'h70;

    typedef enum logic [2:0] {
        FLD_EN, FLD_BHI, FLD_BLO, FLD_IRQ, FLD_NONE
    } fld_e;

    typedef struct packed {
        logic             en;
        logic [7:0]       base_hi;
        logic [7:0]       base_lo;
        logic [IRQ_W-1:0] irq;
    } dev_cfg_t;

    // Base address chosen by the high-priority strap of a device.
    function automatic logic [15:0] prio_base(int dev);
        case (dev)
            0:       return 16'h03F8;
            1:       return 16'h02F8;
            default: return 16'h0442;
        endcase
    endfunction

    // Base address chosen by the low-priority strap of a device.
    function automatic logic [15:0] alt_base(int dev);
        case (dev)
            0:       return 16'h03E0;
            1:       return 16'h02E0;
            default: return 16'h0000;
        endcase
    endfunction

    // Interrupt select loaded when any strap of a device is active.
    function automatic logic [IRQ_W-1:0] strap_irq(int dev);
        case (dev)
            0:       return 4'h3;
            1:       return 4'h4;
            default: return 4'h0;
        endcase
    endfunction

    // Maps a register number to the per-device field it names.
    function automatic fld_e index_field(logic [7:0] idx);
        case (idx)
            IDX_ENABLE:  return FLD_EN;
            IDX_BASE_HI: return FLD_BHI;
            IDX_BASE_LO: return FLD_BLO;
            IDX_IRQ:     return FLD_IRQ;
            default:     return FLD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cfg_strap_decode.sv
// Module: turns the two straps of one device into that device's reset values.
// The high-priority strap wins over the low-priority one. With neither strap
// active every field is zero. Purely combinational.
module cfg_strap_decode
    import cfgbank_pkg::*;
#(
    parameter logic [15:0]      HI_BASE = 16'h03F8,
    parameter logic [15:0]      LO_BASE = 16'h03E0,
    parameter logic [IRQ_W-1:0] IRQ_VAL = 4'h3
) (
    input  logic     strap_hi,
    input  logic     strap_lo,
    output dev_cfg_t dflt
);

    // Purpose: pick the default set from the strap pair by priority.
    always_comb begin
        dflt = '0;
        if (strap_hi) begin
            dflt.en      = 1'b1;
            dflt.base_hi = HI_BASE[15:8];
            dflt.base_lo = HI_BASE[7:0];
            dflt.irq     = IRQ_VAL;
        end else if (strap_lo) begin
            dflt.en      = 1'b1;
            dflt.base_hi = LO_BASE[15:8];
            dflt.base_lo = LO_BASE[7:0];
            dflt.irq     = IRQ_VAL;
        end
    end

endmodule

// File: rtl/cfg_dev_bank.sv
// Module: register set of one logical device (enable, base address, IRQ select).
// It loads the strap-derived defaults while reset is low, so the straps are
// sampled for the last time at reset release. Afterwards only host writes change it.
module cfg_dev_bank
    import cfgbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  dev_cfg_t    dflt,
    input  logic        wr_en,
    input  fld_e        wr_fld,
    input  logic [7:0]  wdata,
    output dev_cfg_t    cfg
);

    dev_cfg_t cfg_q;

    // Purpose: load the defaults during reset, then apply field writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= dflt;
        end else if (wr_en) begin
            case (wr_fld)
                FLD_EN:  cfg_q.en      <= wdata[0];
                FLD_BHI: cfg_q.base_hi <= wdata;
                FLD_BLO: cfg_q.base_lo <= wdata;
                FLD_IRQ: cfg_q.irq     <= wdata[IRQ_W-1:0];
                default: cfg_q         <= cfg_q;
            endcase
        end
    end

    assign cfg = cfg_q;

    // R6 / R7: with no write the set holds its value, whatever the straps do.
    a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));

    // R8: a write to an unimplemented field leaves the set untouched.
    a_r8_none_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fld == FLD_NONE) |=> $stable(cfg_q));

endmodule

// File: rtl/cfg_host_port.sv
// Module: selector/window access front end. It latches the port-pair strap
// during reset, decodes the two port addresses, and holds the register number
// and the device select. Assumes single-cycle read and write strobes.
module cfg_host_port
    import cfgbank_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_STRAP1 = 16'h002E,
    parameter logic [ADDR_W-1:0] PORT_STRAP0 = 16'h004E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_port,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic              sel_hit,
    output logic              win_hit,
    output logic [7:0]        index,
    output logic [7:0]        devsel,
    output fld_e              field,
    output logic              dev_valid
);

    logic [ADDR_W-1:0] port_base_q;
    logic [7:0]        index_q;
    logic [7:0]        devsel_q;

    // Purpose: latch the port pair from the strap while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_base_q <= strap_port ? PORT_STRAP1 : PORT_STRAP0;
        end
    end

    assign sel_hit = (io_addr == port_base_q);
    assign win_hit = (io_addr == port_base_q + ADDR_W'(1));

    // Purpose: keep the register number written through the selector port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
        end else if (io_wr && sel_hit) begin
            index_q <= io_wdata;
        end
    end

    // Purpose: keep the device select written through the window at 0x07.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            devsel_q <= '0;
        end else if (io_wr && win_hit && index_q == IDX_DEVSEL) begin
            devsel_q <= io_wdata;
        end
    end

    assign index     = index_q;
    assign devsel    = devsel_q;
    assign field     = index_field(index_q);
    assign dev_valid = (devsel_q < 8'(NUM_DEV));

    // R2: the register number changes only through a selector-port write.
    a_r2_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && sel_hit) |=> $stable(index_q));

    // R9: the device select changes only through a window write at 0x07.
    a_r9_devsel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && win_hit && index_q == IDX_DEVSEL) |=> $stable(devsel_q));

    // R1 / R7: the port pair never moves once reset is released.
    a_r1_port_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(port_base_q));

endmodule

// File: rtl/cfg_strap_bank.sv
// Module: top of the strap-loaded configuration bank. It holds one decoder and
// one register set per logical device, the host front end and the registered
// read-data path. Assumes the host never asserts read and write together.
module cfg_strap_bank
    import cfgbank_pkg::*;
#(
    parameter logic [15:0] PORT_STRAP1 = 16'h002E,
    parameter logic [15:0] PORT_STRAP0 = 16'h004E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_port,
    input  logic        strap_a_3f8,
    input  logic        strap_a_3e0,
    input  logic        strap_b_2f8,
    input  logic        strap_b_2e0,
    input  logic        strap_wdt,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata
);

    logic             sel_hit, win_hit, dev_valid;
    logic [7:0]       index, devsel;
    fld_e             field;
    logic [NUM_DEV-1:0] strap_hi, strap_lo;
    dev_cfg_t         dflt [NUM_DEV];
    dev_cfg_t         cfg  [NUM_DEV];
    dev_cfg_t         cur;
    logic [7:0]       win_rd_val;
    logic [7:0]       rdata_q;

    assign strap_hi = {strap_wdt, strap_b_2f8, strap_a_3f8};
    assign strap_lo = {1'b0,      strap_b_2e0, strap_a_3e0};

    cfg_host_port #(
        .PORT_STRAP1 (PORT_STRAP1),
        .PORT_STRAP0 (PORT_STRAP0)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_port (strap_port),
        .io_addr    (io_addr),
        .io_wr      (io_wr),
        .io_wdata   (io_wdata),
        .sel_hit    (sel_hit),
        .win_hit    (win_hit),
        .index      (index),
        .devsel     (devsel),
        .field      (field),
        .dev_valid  (dev_valid)
    );

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        cfg_strap_decode #(
            .HI_BASE (prio_base(d)),
            .LO_BASE (alt_base(d)),
            .IRQ_VAL (strap_irq(d))
        ) u_dec (
            .strap_hi (strap_hi[d]),
            .strap_lo (strap_lo[d]),
            .dflt     (dflt[d])
        );

        cfg_dev_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .dflt   (dflt[d]),
            .wr_en  (io_wr && win_hit && dev_valid && devsel == 8'(d)),
            .wr_fld (field),
            .wdata  (io_wdata),
            .cfg    (cfg[d])
        );
    end

    // Purpose: pick the register set named by the device select.
    always_comb begin
        cur = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (devsel == 8'(d)) cur = cfg[d];
        end
    end

    // Purpose: form the value a window read returns for the current number.
    always_comb begin
        win_rd_val = '0;
        if (index == IDX_DEVSEL) begin
            win_rd_val = devsel;
        end else if (dev_valid) begin
            case (field)
                FLD_EN:  win_rd_val = {7'b0, cur.en};
                FLD_BHI: win_rd_val = cur.base_hi;
                FLD_BLO: win_rd_val = cur.base_lo;
                FLD_IRQ: win_rd_val = {{(8-IRQ_W){1'b0}}, cur.irq};
                default: win_rd_val = '0;
            endcase
        end
    end

    // Purpose: register read data for one cycle after each port read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (io_rd && sel_hit) begin
            rdata_q <= index;
        end else if (io_rd && win_hit) begin
            rdata_q <= win_rd_val;
        end else begin
            rdata_q <= '0;
        end
    end

    assign io_rdata = rdata_q;

    // R10: no port read in a cycle means zero read data in the next one.
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && (sel_hit || win_hit)) |=> (io_rdata == 8'h00));

    // R8: a window read of an unimplemented number returns zero.
    a_r8_unimpl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && win_hit && index != IDX_DEVSEL && field == FLD_NONE)
        |=> (io_rdata == 8'h00));

    // R2: a selector-port read returns the number held before that read.
    a_r2_index_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && sel_hit) |=> (io_rdata == $past(index)));

endmodule

// File: tb/cfg_strap_bank_tb.sv
// Bench: a behavioural model (integer arrays) tracks every register and the
// expected read data; it is compared with the DUT on each falling edge.
module cfg_strap_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_port = 1'b1;
    logic        strap_a_3f8 = 1'b0, strap_a_3e0 = 1'b0;
    logic        strap_b_2f8 = 1'b0, strap_b_2e0 = 1'b0;
    logic        strap_wdt = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;

    always #2 clk = ~clk;   // 250 MHz

    cfg_strap_bank u_dut (
        .clk(clk), .rst_n(rst_n), .strap_port(strap_port),
        .strap_a_3f8(strap_a_3f8), .strap_a_3e0(strap_a_3e0),
        .strap_b_2f8(strap_b_2f8), .strap_b_2e0(strap_b_2e0),
        .strap_wdt(strap_wdt), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    // ---- reference model ----
    int m_reg [3][4];   // field 0 enable, 1 base high, 2 base low, 3 irq
    int m_index, m_dev, m_port, m_exp;

    function automatic int field_of(int idx);
        if (idx == 'h30) return 0;
        if (idx == 'h60) return 1;
        if (idx == 'h61) return 2;
        if (idx == 'h70) return 3;
        return -1;
    endfunction

    task automatic load_dev(int d, int on, int base, int irq);
        m_reg[d][0] = on;
        m_reg[d][1] = on ? (base >> 8) : 0;
        m_reg[d][2] = on ? (base & 'hFF) : 0;
        m_reg[d][3] = on ? irq : 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            load_dev(0, int'(strap_a_3f8 | strap_a_3e0), strap_a_3f8 ? 'h3F8 : 'h3E0, 3);
            load_dev(1, int'(strap_b_2f8 | strap_b_2e0), strap_b_2f8 ? 'h2F8 : 'h2E0, 4);
            load_dev(2, int'(strap_wdt), 'h442, 0);
            m_port  = strap_port ? 'h2E : 'h4E;
            m_index = 0;
            m_dev   = 0;
            m_exp   = 0;
        end else begin
            int f;
            m_exp = 0;
            f = field_of(m_index);
            if (io_rd && int'(io_addr) == m_port) m_exp = m_index;
            if (io_rd && int'(io_addr) == m_port + 1) begin
                if (m_index == 'h07) m_exp = m_dev;
                else if (f >= 0 && m_dev < 3) m_exp = m_reg[m_dev][f];
            end
            if (io_wr && int'(io_addr) == m_port) m_index = int'(io_wdata);
            else if (io_wr && int'(io_addr) == m_port + 1) begin
                if (m_index == 'h07) m_dev = int'(io_wdata);
                else if (f >= 0 && m_dev < 3) begin
                    case (f)
                        0: m_reg[m_dev][0] = int'(io_wdata) & 1;
                        3: m_reg[m_dev][3] = int'(io_wdata) & 'hF;
                        default: m_reg[m_dev][f] = int'(io_wdata);
                    endcase
                end
            end
        end
    end

    // Per-cycle comparison of read data against the model (R10).
    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (int'(io_rdata) != m_exp) begin
                errors++;
                $display("FAIL R10 cycle %0d: io_rdata=%02h expected %02h", cyc, io_rdata, m_exp);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // ---- host tasks ----
    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_check(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        vectors++;
        if (io_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %04h: got %02h expected %02h", tag, a, io_rdata, exp);
        end
    endtask

    task automatic reg_check(input logic [15:0] port, input logic [7:0] idx,
                             input logic [7:0] exp, input string tag);
        io_write(port, idx);
        io_check(port + 16'd1, exp, tag);
    endtask

    task automatic dev_check(input logic [15:0] port, input logic [7:0] dev,
                             input logic [7:0] en, input logic [15:0] base,
                             input logic [7:0] irq, input string tag);
        io_write(port, 8'h07);
        io_write(port + 16'd1, dev);
        reg_check(port, 8'h30, en, tag);
        reg_check(port, 8'h60, base[15:8], tag);
        reg_check(port, 8'h61, base[7:0], tag);
        reg_check(port, 8'h70, irq, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // Reset with both A straps, B low strap only, watchdog on, port 0x2E.
        strap_a_3f8 = 1; strap_a_3e0 = 1; strap_b_2e0 = 1; strap_wdt = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (io_rdata !== 8'h00) begin
            errors++;
            $display("FAIL R10 reset: io_rdata=%02h expected 00", io_rdata);
        end
        dev_check(16'h002E, 8'd0, 8'h01, 16'h03F8, 8'h03, "R3 both A straps, 3F8 wins");
        dev_check(16'h002E, 8'd1, 8'h01, 16'h02E0, 8'h04, "R4 B 2E0 strap");
        dev_check(16'h002E, 8'd2, 8'h01, 16'h0442, 8'h00, "R5 watchdog strap on");
        io_check(16'h002E, 8'h70, "R2 selector readback");
        reg_check(16'h002E, 8'h07, 8'h02, "R9 device select readback");
        io_check(16'h004E, 8'h00, "R1 other port pair ignored");

        // Straps change after reset: nothing moves (R7).
        strap_a_3f8 = 0; strap_a_3e0 = 0; strap_b_2f8 = 1; strap_wdt = 0; strap_port = 0;
        dev_check(16'h002E, 8'd0, 8'h01, 16'h03F8, 8'h03, "R7 straps ignored A");
        dev_check(16'h002E, 8'd2, 8'h01, 16'h0442, 8'h00, "R7 straps ignored wdt");

        // Overrides (R6).
        io_write(16'h002E, 8'h07); io_write(16'h002F, 8'h01);
        io_write(16'h002E, 8'h60); io_write(16'h002F, 8'hA5);
        io_write(16'h002E, 8'h30); io_write(16'h002F, 8'hFE);
        io_write(16'h002E, 8'h70); io_write(16'h002F, 8'hFB);
        dev_check(16'h002E, 8'd1, 8'h00, 16'hA5E0, 8'h0B, "R6 override channel B");
        dev_check(16'h002E, 8'd0, 8'h01, 16'h03F8, 8'h03, "R6 channel A untouched");

        // Unimplemented number and invalid device (R8).
        io_write(16'h002E, 8'h22); io_write(16'h002F, 8'h5A);
        reg_check(16'h002E, 8'h22, 8'h00, "R8 unimplemented number");
        io_write(16'h002E, 8'h07); io_write(16'h002F, 8'h05);
        io_write(16'h002E, 8'h61); io_write(16'h002F, 8'h77);
        reg_check(16'h002E, 8'h61, 8'h00, "R8 device select 5 reads zero");
        reg_check(16'h002E, 8'h07, 8'h05, "R9 device select holds 5");
        dev_check(16'h002E, 8'd0, 8'h01, 16'h03F8, 8'h03, "R8 invalid device write ignored");
        dev_check(16'h002E, 8'd1, 8'h00, 16'hA5E0, 8'h0B, "R8 channel B unchanged");

        // Second reset: port 0x4E, A none, B both, watchdog off.
        strap_port = 0; strap_a_3f8 = 0; strap_a_3e0 = 0;
        strap_b_2f8 = 1; strap_b_2e0 = 1; strap_wdt = 0;
        do_reset();
        reg_check(16'h004E, 8'h07, 8'h00, "R9 device select reset");
        dev_check(16'h004E, 8'd0, 8'h00, 16'h0000, 8'h00, "R3 no A strap");
        dev_check(16'h004E, 8'd1, 8'h01, 16'h02F8, 8'h04, "R4 both B straps, 2F8 wins");
        dev_check(16'h004E, 8'd2, 8'h00, 16'h0000, 8'h00, "R5 watchdog strap off");
        io_write(16'h002E, 8'h30);
        io_check(16'h002E, 8'h00, "R1 old pair ignored");
        io_check(16'h004E, 8'h70, "R1 selector unaffected by old pair");

        // Third reset: A low strap only, B none.
        strap_port = 1; strap_a_3e0 = 1; strap_b_2f8 = 0; strap_b_2e0 = 0;
        do_reset();
        dev_check(16'h002E, 8'd0, 8'h01, 16'h03E0, 8'h03, "R3 A 3E0 strap only");
        dev_check(16'h002E, 8'd1, 8'h00, 16'h0000, 8'h00, "R4 no B strap");

        repeat (3) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule